// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the timing strobes of a multiplexed external memory bus for an 8-bit microcontroller core. It owns the machine-cycle sequencer. One machine cycle is six states of two phases each, so it lasts twelve oscillator clocks. From the sequencer it produces the address-latch strobe, the active-low program-fetch strobe and the active-low data read and write strobes.

The core tells the block three things: whether the next machine cycle moves external data and in which direction, whether a code-table read is under way, and whether the current fetch address lies beyond on-chip program memory. The block latches the external-access strap pin while reset is held. That strap, together with the fetch-address hint, decides whether program fetches go to the external bus.

A control-register bit can silence the address-latch strobe when no external access is taking place. In that case the pad is held high through a weak pull-up. External execution overrides this bit.

Top module: `memstrobe_gen`

## Requirements
- R1: The first clock edge after reset release starts tick 0 of a machine cycle, and a cycle has 12 ticks. With no data cycle and no suppression, `ale` is high exactly at ticks 1, 2, 7 and 8. This gives two pulses per machine cycle, each pulse 2 ticks wide.
- R2: If `xdata_req` is high at the edge that starts tick 11, the following machine cycle is a data cycle. In a data cycle the ALE pulse at ticks 1–2 is omitted and the pulse at ticks 7–8 is kept.
- R3: In external execution, `psen_n` is low exactly at ticks 3, 4, 5, 9, 10 and 11 of every cycle that is not a data cycle. External execution means the latched strap was low, or `fetch_ext` is high. In internal execution `psen_n` stays high.
- R4: `psen_n` stays high for the whole of a data cycle, even in external execution.
- R5: In a data cycle, `rd_n` is low at ticks 0–5 when `xdata_wr` was 0 at the sampling edge of R2, and `wr_n` is low at ticks 0–5 when it was 1. Neither strobe is low outside ticks 0–5 of a data cycle, and the two are never low together.
- R6: When `ale_off` is 1 in internal execution, with `xdata_req` and `ctab_req` both low and no data cycle, `ale` and `ale_weak` are both 1 for the whole cycle. If `ctab_req` or `xdata_req` is high, or the cycle is a data cycle, the R1/R2 pulses return and `ale_weak` is 0.
- R7: In external execution `ale_off` has no effect: `ale` pulses as in R1/R2 and `ale_weak` stays 0.
- R8: `ext_access_n` is latched on every clock while `rst_n` is low. Changes after reset release do not change fetch behaviour until the next reset.
- R9: While `rst_n` is low, the outputs are `ale`=0, `ale_weak`=0, `psen_n`=1, `rd_n`=1 and `wr_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_access_n | input | 1 | External-access strap, low selects external program memory, latched during reset |
| fetch_ext | input | 1 | Current fetch address lies beyond on-chip program memory |
| xdata_req | input | 1 | Next machine cycle is an external data move |
| xdata_wr | input | 1 | Direction of that data move: 1 write, 0 read |
| ctab_req | input | 1 | A code-table read instruction is active |
| ale_off | input | 1 | Control-register bit: suppress ALE outside external accesses |
| ale | output | 1 | Address latch enable strobe |
| ale_weak | output | 1 | ALE pad held high only by weak pull-up |
| psen_n | output | 1 | Program-fetch strobe, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |

## Verification
Two functions can land in the same machine cycle: the ALE suppression bit and the data-cycle pulse rules. The external-execution override can also coincide with suppression. The vector table sets `ale_off` together with a data request, with a data cycle, with a code-table read and with `fetch_ext`. In each case it checks, tick by tick, that the pulses return with the first pulse still omitted in the data cycle and `ale_weak` low. Separate resets with both strap levels, followed by a strap flip after release, show that the latched level alone decides fetch strobes and the override.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int STATES = 6;
  localparam int PHASES = 2;
  localparam int TICKS  = STATES * PHASES;
  localparam int TICK_W = $clog2(TICKS);

  typedef logic [TICK_W-1:0] tick_t;

  // Tick index of state s (1-based), phase p (1-based)
  function automatic int tick_of(input int s, input int p);
    return (s - 1) * PHASES + (p - 1);
  endfunction

  // ALE window: S1P2..S2P1 and S4P2..S5P1
  function automatic logic ale_win(input int t);
    return (t >= tick_of(1, 2) && t <= tick_of(2, 1)) ||
           (t >= tick_of(4, 2) && t <= tick_of(5, 1));
  endfunction

  // Program-fetch window: S2P2..S3P2 and S5P2..S6P2
  function automatic logic psen_win(input int t);
    return (t >= tick_of(2, 2) && t <= tick_of(3, 2)) ||
           (t >= tick_of(5, 2) && t <= tick_of(6, 2));
  endfunction

  // First half of the cycle: data strobe window, and the region of the skipped ALE
  function automatic logic first_half(input int t);
    return t <= tick_of(3, 2);
  endfunction
endpackage

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import strobe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_t tick,
  output tick_t tick_next,
  output logic  samp_edge,
  output logic  wrap_edge
);
  localparam tick_t LAST = tick_t'(TICKS - 1);
  localparam tick_t PRE  = tick_t'(TICKS - 2);

  assign tick_next = (tick == LAST) ? '0 : tick + tick_t'(1);
  assign samp_edge = (tick == PRE);
  assign wrap_edge = (tick == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= LAST;
    else        tick <= tick_next;
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tick) < TICKS); // R1
endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_access_n,
  input  logic fetch_ext,
  input  logic xdata_req,
  input  logic xdata_wr,
  input  logic samp_edge,
  input  logic wrap_edge,
  output logic ext_exec,
  output logic dcyc,
  output logic dcyc_next,
  output logic dwr_next,
  output logic strap_q
);
  logic pend, pend_wr, dwr;

  // Strap captured on each clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= ext_access_n;
  end

  assign ext_exec = !strap_q || fetch_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      pend_wr <= 1'b0;
    end else if (samp_edge) begin
      pend    <= xdata_req;
      pend_wr <= xdata_wr;
    end
  end

  assign dcyc_next = wrap_edge ? pend    : dcyc;
  assign dwr_next  = wrap_edge ? pend_wr : dwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcyc <= 1'b0;
      dwr  <= 1'b0;
    end else begin
      dcyc <= dcyc_next;
      dwr  <= dwr_next;
    end
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q)); // R8
endmodule

// File: rtl/bus_strobe_out.sv
module bus_strobe_out
  import strobe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t tick_next,
  input  logic  dcyc_next,
  input  logic  dwr_next,
  input  logic  ext_exec,
  input  logic  ale_off,
  input  logic  xdata_req,
  input  logic  ctab_req,
  output logic  ale,
  output logic  ale_weak,
  output logic  psen_n,
  output logic  rd_n,
  output logic  wr_n
);
  logic ale_allow, early, ale_d, psen_d, rd_d, wr_d;
  int   tn;

  assign tn        = int'(tick_next);
  assign early     = first_half(tn);
  assign ale_allow = !ale_off || ext_exec || xdata_req || ctab_req || dcyc_next;

  always_comb begin
    ale_d  = ale_allow ? (ale_win(tn) && !(dcyc_next && early)) : 1'b1;
    psen_d = !(ext_exec && !dcyc_next && psen_win(tn));
    rd_d   = !(dcyc_next && !dwr_next && early);
    wr_d   = !(dcyc_next &&  dwr_next && early);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale      <= 1'b0;
      ale_weak <= 1'b0;
      psen_n   <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
    end else begin
      ale      <= ale_d;
      ale_weak <= !ale_allow;
      psen_n   <= psen_d;
      rd_n     <= rd_d;
      wr_n     <= wr_d;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R5
  AST_WEAK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ale_weak |-> ale); // R6
  AST_ALE_PSEN_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !ale_weak) |-> psen_n); // R3
endmodule

// File: rtl/memstrobe_gen.sv
module memstrobe_gen
  import strobe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_access_n,
  input  logic fetch_ext,
  input  logic xdata_req,
  input  logic xdata_wr,
  input  logic ctab_req,
  input  logic ale_off,
  output logic ale,
  output logic ale_weak,
  output logic psen_n,
  output logic rd_n,
  output logic wr_n
);
  tick_t tick, tick_next;
  logic  samp_edge, wrap_edge;
  logic  ext_exec, dcyc, dcyc_next, dwr_next, strap_q;

  bus_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tick_next (tick_next),
    .samp_edge (samp_edge),
    .wrap_edge (wrap_edge)
  );

  bus_cycle_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_access_n (ext_access_n),
    .fetch_ext    (fetch_ext),
    .xdata_req    (xdata_req),
    .xdata_wr     (xdata_wr),
    .samp_edge    (samp_edge),
    .wrap_edge    (wrap_edge),
    .ext_exec     (ext_exec),
    .dcyc         (dcyc),
    .dcyc_next    (dcyc_next),
    .dwr_next     (dwr_next),
    .strap_q      (strap_q)
  );

  bus_strobe_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_next (tick_next),
    .dcyc_next (dcyc_next),
    .dwr_next  (dwr_next),
    .ext_exec  (ext_exec),
    .ale_off   (ale_off),
    .xdata_req (xdata_req),
    .ctab_req  (ctab_req),
    .ale       (ale),
    .ale_weak  (ale_weak),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  AST_PSEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dcyc |-> psen_n); // R4
  AST_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> dcyc); // R5
  AST_FIRST_ALE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (dcyc && (tick == tick_t'(1) || tick == tick_t'(2))) |-> !ale); // R2
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_q || fetch_ext) |=> !ale_weak); // R7
endmodule

// File: tb/memstrobe_gen_tb_top.sv
module memstrobe_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_access_n = 1'b1;
  logic fetch_ext = 1'b0, xdata_req = 1'b0, xdata_wr = 1'b0;
  logic ctab_req = 1'b0, ale_off = 1'b0;
  logic ale, ale_weak, psen_n, rd_n, wr_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  memstrobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ext_access_n(ext_access_n),
    .fetch_ext(fetch_ext), .xdata_req(xdata_req), .xdata_wr(xdata_wr),
    .ctab_req(ctab_req), .ale_off(ale_off),
    .ale(ale), .ale_weak(ale_weak), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // Row: {ale_off, fetch_ext, xreq, xwr, ctab, weak, ale mask, psen-low mask, rd-low mask, wr-low mask}
  localparam int NROW = 13;
  localparam logic [53:0] VEC [NROW] = '{
    {5'b00000, 1'b0, 12'h186, 12'h000, 12'h000, 12'h000}, // 0  R1 internal
    {5'b01000, 1'b0, 12'h186, 12'hE38, 12'h000, 12'h000}, // 1  R3 external fetch
    {5'b01100, 1'b0, 12'h186, 12'hE38, 12'h000, 12'h000}, // 2  read request
    {5'b01000, 1'b0, 12'h180, 12'h000, 12'h03F, 12'h000}, // 3  R2 R4 R5 read cycle
    {5'b01110, 1'b0, 12'h186, 12'hE38, 12'h000, 12'h000}, // 4  write request
    {5'b01000, 1'b0, 12'h180, 12'h000, 12'h000, 12'h03F}, // 5  R5 write cycle
    {5'b10000, 1'b1, 12'hFFF, 12'h000, 12'h000, 12'h000}, // 6  R6 suppressed
    {5'b10001, 1'b0, 12'h186, 12'h000, 12'h000, 12'h000}, // 7  R6 code-table read
    {5'b11000, 1'b0, 12'h186, 12'hE38, 12'h000, 12'h000}, // 8  R7 override
    {5'b10100, 1'b0, 12'h186, 12'h000, 12'h000, 12'h000}, // 9  R6 request revives
    {5'b10000, 1'b0, 12'h180, 12'h000, 12'h03F, 12'h000}, // 10 R6 data cycle revives
    {5'b10000, 1'b1, 12'hFFF, 12'h000, 12'h000, 12'h000}, // 11 R6 suppressed again
    {5'b00000, 1'b0, 12'h186, 12'h000, 12'h000, 12'h000}  // 12 R1 back to normal
  };

  function automatic string ale_tag(input int r);
    case (r)
      3, 5, 10:    return "R2";
      6, 7, 9, 11: return "R6";
      8:           return "R7";
      default:     return "R1";
    endcase
  endfunction

  function automatic string psen_tag(input int r);
    if (r == 3 || r == 5 || r == 10) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  // One machine cycle, checking every tick against the masks (bit t = tick t)
  task automatic run_cycle(input string at, input string pt, input string wt,
                           input logic [11:0] am, input logic [11:0] pm,
                           input logic [11:0] rm, input logic [11:0] wm, input logic wk);
    for (int t = 0; t < 12; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk(at, $sformatf("ale tick %0d", t), ale, am[t]);
      chk(wt, $sformatf("ale_weak tick %0d", t), ale_weak, wk);
      chk(pt, $sformatf("psen_n tick %0d", t), psen_n, !pm[t]);
      chk("R5", $sformatf("rd_n tick %0d", t), rd_n, !rm[t]);
      chk("R5", $sformatf("wr_n tick %0d", t), wr_n, !wm[t]);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    ext_access_n = strap;
    {ale_off, fetch_ext, xdata_req, xdata_wr, ctab_req} = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "ale in reset", ale, 1'b0);
    chk("R9", "ale_weak in reset", ale_weak, 1'b0);
    chk("R9", "psen_n in reset", psen_n, 1'b1);
    chk("R9", "rd_n in reset", rd_n, 1'b1);
    chk("R9", "wr_n in reset", wr_n, 1'b1);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    for (int r = 0; r < NROW; r++) begin
      {ale_off, fetch_ext, xdata_req, xdata_wr, ctab_req} = VEC[r][53:49];
      run_cycle(ale_tag(r), psen_tag(r), "R6", VEC[r][47:36], VEC[r][35:24],
                VEC[r][23:12], VEC[r][11:0], VEC[r][48]);
    end

    // R8 R7: strap low latched in reset, pin raised afterwards, suppression requested
    do_reset(1'b0);
    ext_access_n = 1'b1;
    ale_off = 1'b1;
    run_cycle("R7", "R8", "R7", 12'h186, 12'hE38, 12'h000, 12'h000, 1'b0);

    // R8: strap high latched in reset, pin lowered afterwards -> fetch strobe stays idle
    do_reset(1'b1);
    ext_access_n = 1'b0;
    run_cycle("R1", "R8", "R6", 12'h186, 12'h000, 12'h000, 12'h000, 1'b0);

    // R8 with suppression: internal execution still, so pad sits weakly high
    ale_off = 1'b1;
    run_cycle("R6", "R8", "R6", 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule